// File: doc/BRIEF.md
# Serial Shift-Register Cascade Driver

This block keeps a 24-bit output image on a chain of up to three external 8-bit serial-in/parallel-out registers, such as those that drive LEDs or spare GPIO pins. It shifts the image out over three wires: a shift clock, a data line and a store strobe that moves the shifted bits onto the parallel outputs. Software programs the image through a small write port. Selected low bits of the cascade can also be handed to hardware status sources: a DSL modem status pair and up to four Ethernet PHY link/activity triples. These sources then refresh those bits without any software action.

The block watches the merged image, which is the software bits with any bits claimed by hardware sources replaced by the source values. Whenever the merged image differs from the image last sent, it sends a new frame. A frame holds only the enabled 8-bit groups. Its bits go out most-significant enabled bit first, and a one-cycle store pulse follows the last bit. The write-port map is: address 0 is the software image [23:0]; address 1 is the group mask [2:0]; address 2 is the DSL enable [1:0]; address 3 is the PHY enables [11:0], with PHY n at bits [3n+2:3n]; address 4 is the clock control, with bit 0 selecting the rising edge and bits [11:4] holding the half-period N.

The controller runs in four states. SH_IDLE waits for a change. The "start" transition goes to SH_SETUP, where the clock sits at its inactive level and the data is presented. The "half done" transition goes to SH_DRIVE, where the clock sits at its active level. From SH_DRIVE, the "next bit" transition returns to SH_SETUP, and the "last bit" transition goes to SH_STORE, which pulses the strobe. The "store done" transition then returns to SH_IDLE.

Top module: `sro_cascade_drv`

## Requirements
- R1: After reset, the software image equals the default 24'h00FF00 and is taken as already present on the cascade. The group mask is 3'b111, the DSL and PHY enables are 0, the falling edge is selected, and N is 2. The shift clock idles high, the store strobe is low, and no frame is sent until the merged image changes.
- R2: With all groups enabled, a frame is 24 bits long and carries merged bits 23 down to 0 in that order, one bit per active clock edge.
- R3: Only groups whose mask bit is set are sent. Mask bit g covers image bits [8g+7:8g], and higher enabled groups go first. With mask 0 no frame is sent, and the pending change goes out once a group is enabled again.
- R4: After the last active edge of a frame, the store output is high for exactly one system cycle.
- R5: When control bit 0 is 1, data is valid at rising shift-clock edges and the clock idles low. When it is 0, data is valid at falling edges and the clock idles high.
- R6: Consecutive active shift-clock edges within a frame are 2N system cycles apart. A value of N = 0 acts as N = 1.
- R7: When DSL enable bit k is set, cascade bit k takes the value of DSL status input k. Bits whose enable is clear keep the software value.
- R8: When PHY n's enable bit j is set, cascade bit 2+3n+j takes the value of PHY status input 3n+j. Bits whose enable is clear keep the software value.
- R9: A frame starts by itself when the merged image changes, including a change made only by a status input. Writing a value that leaves the merged image unchanged sends no frame.
- R10: A frame in progress is never cut short. A change that arrives during it is sent in one following frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 24 | Register write data |
| dsl_stat | input | 2 | DSL status bits |
| phy_stat | input | 12 | PHY status bits, three per PHY |
| sclk | output | 1 | Shift clock to the cascade |
| sdata | output | 1 | Serial data to the cascade |
| sstore | output | 1 | Store/latch strobe to the cascade |

## Verification
Two functions can fall into the same cycle: a new image can arrive while the shifter is busy sending an earlier one, and a status source can change the merged image just as software writes to it. The bench provokes the first case by writing a second image after the fifth captured bit of a running frame. It judges the result by checking that the first frame holds the old image intact and that exactly one more frame follows with the new one. The status-only path is checked by toggling a DSL input with no write and requiring a fresh frame with the updated bit.

// File: rtl/sro_pkg.sv
package sro_pkg;

    typedef enum logic [1:0] {
        SH_IDLE,
        SH_SETUP,
        SH_DRIVE,
        SH_STORE
    } sh_state_e;

    localparam logic [2:0] ADDR_IMAGE = 3'd0;
    localparam logic [2:0] ADDR_GROUP = 3'd1;
    localparam logic [2:0] ADDR_DSL   = 3'd2;
    localparam logic [2:0] ADDR_PHY   = 3'd3;
    localparam logic [2:0] ADDR_CTRL  = 3'd4;

    localparam int CTRL_DIV_LSB = 4;

endpackage

// File: rtl/sro_cfg_regs.sv
module sro_cfg_regs
    import sro_pkg::*;
#(
    parameter int IMG_W    = 24,
    parameter int GROUPS   = 3,
    parameter int DSL_BITS = 2,
    parameter int PHY_EN_W = 12,
    parameter int DIV_W    = 8,
    parameter logic [IMG_W-1:0] DEFAULT_IMG = 24'h00FF00
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [2:0]          wr_addr,
    input  logic [IMG_W-1:0]    wr_data,
    output logic [IMG_W-1:0]    sw_img,
    output logic [GROUPS-1:0]   grp_mask,
    output logic [DSL_BITS-1:0] dsl_en,
    output logic [PHY_EN_W-1:0] phy_en,
    output logic                rising,
    output logic [DIV_W-1:0]    half_n
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sw_img   <= DEFAULT_IMG;
            grp_mask <= '1;
            dsl_en   <= '0;
            phy_en   <= '0;
            rising   <= 1'b0;
            half_n   <= DIV_W'(2);
        end else if (wr_en) begin
            unique case (wr_addr)
                ADDR_IMAGE: sw_img   <= wr_data;
                ADDR_GROUP: grp_mask <= wr_data[GROUPS-1:0];
                ADDR_DSL:   dsl_en   <= wr_data[DSL_BITS-1:0];
                ADDR_PHY:   phy_en   <= wr_data[PHY_EN_W-1:0];
                ADDR_CTRL: begin
                    rising <= wr_data[0];
                    half_n <= wr_data[CTRL_DIV_LSB +: DIV_W];
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/sro_src_merge.sv
module sro_src_merge #(
    parameter int IMG_W    = 24,
    parameter int DSL_BITS = 2,
    parameter int PHYS     = 4,
    parameter int PHY_BITS = 3
) (
    input  logic [IMG_W-1:0]           sw_img,
    input  logic [DSL_BITS-1:0]        dsl_en,
    input  logic [DSL_BITS-1:0]        dsl_stat,
    input  logic [PHYS*PHY_BITS-1:0]   phy_en,
    input  logic [PHYS*PHY_BITS-1:0]   phy_stat,
    output logic [IMG_W-1:0]           img_merged
);

    localparam int HW_W = DSL_BITS + PHYS * PHY_BITS;

    logic [IMG_W-1:0] hw_en;
    logic [IMG_W-1:0] hw_val;

    assign hw_en[DSL_BITS-1:0]  = dsl_en;
    assign hw_val[DSL_BITS-1:0] = dsl_stat;

    for (genvar p = 0; p < PHYS; p++) begin : g_phy
        localparam int BASE = DSL_BITS + p * PHY_BITS;
        assign hw_en[BASE +: PHY_BITS]  = phy_en[p*PHY_BITS +: PHY_BITS];
        assign hw_val[BASE +: PHY_BITS] = phy_stat[p*PHY_BITS +: PHY_BITS];
    end

    if (IMG_W > HW_W) begin : g_upper
        assign hw_en[IMG_W-1:HW_W]  = '0;
        assign hw_val[IMG_W-1:HW_W] = '0;
    end

    for (genvar i = 0; i < IMG_W; i++) begin : g_bit
        assign img_merged[i] = hw_en[i] ? hw_val[i] : sw_img[i];
    end

endmodule

// File: rtl/sro_shift_fsm.sv
module sro_shift_fsm
    import sro_pkg::*;
#(
    parameter int IMG_W  = 24,
    parameter int GW     = 8,
    parameter int GROUPS = 3,
    parameter int DIV_W  = 8,
    parameter logic [IMG_W-1:0] DEFAULT_IMG = 24'h00FF00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IMG_W-1:0]  img_merged,
    input  logic [GROUPS-1:0] grp_mask,
    input  logic              rising,
    input  logic [DIV_W-1:0]  half_n,
    output logic              sclk,
    output logic              sdata,
    output logic              sstore,
    output logic              busy
);

    localparam int CNT_W = $clog2(IMG_W + 1);

    function automatic logic [IMG_W-1:0] pack_img(input logic [IMG_W-1:0] img,
                                                  input logic [GROUPS-1:0] m);
        logic [IMG_W-1:0] f;
        int n;
        f = '0;
        n = 0;
        for (int g = 0; g < GROUPS; g++) begin
            if (m[g]) begin
                f = f | ({{(IMG_W-GW){1'b0}}, img[g*GW +: GW]} << n);
                n = n + GW;
            end
        end
        return f;
    endfunction

    sh_state_e        state_q, state_d;
    logic [IMG_W-1:0] sent_q;
    logic [IMG_W-1:0] frame_q;
    logic [CNT_W-1:0] bidx_q;
    logic [DIV_W-1:0] hcnt_q;
    logic [DIV_W-1:0] half_lim;
    logic [CNT_W-1:0] frame_len;
    logic [IMG_W-1:0] packed_img;
    logic             start;
    logic             hdone;
    logic             sdata_q;

    assign half_lim   = (half_n == '0) ? DIV_W'(1) : half_n;
    assign hdone      = (hcnt_q == half_lim - DIV_W'(1));
    assign frame_len  = CNT_W'($countones(grp_mask) * GW);
    assign packed_img = pack_img(img_merged, grp_mask);
    assign start      = (img_merged != sent_q) && (|grp_mask);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SH_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SH_IDLE:  if (start) state_d = SH_SETUP;
            SH_SETUP: if (hdone) state_d = SH_DRIVE;
            SH_DRIVE: if (hdone) state_d = (bidx_q == '0) ? SH_STORE : SH_SETUP;
            SH_STORE: state_d = SH_IDLE;
            default:  state_d = SH_IDLE;
        endcase
    end

    // frame data, bit index and half-period counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sent_q  <= DEFAULT_IMG;
            frame_q <= '0;
            bidx_q  <= '0;
            hcnt_q  <= '0;
            sdata_q <= 1'b0;
        end else begin
            unique case (state_q)
                SH_IDLE: begin
                    hcnt_q <= '0;
                    if (start) begin
                        frame_q <= packed_img;
                        sent_q  <= img_merged;
                        bidx_q  <= frame_len - CNT_W'(1);
                        sdata_q <= packed_img[frame_len - CNT_W'(1)];
                    end
                end
                SH_SETUP: hcnt_q <= hdone ? '0 : hcnt_q + DIV_W'(1);
                SH_DRIVE: begin
                    hcnt_q <= hdone ? '0 : hcnt_q + DIV_W'(1);
                    if (hdone && bidx_q != '0) begin
                        bidx_q  <= bidx_q - CNT_W'(1);
                        sdata_q <= frame_q[bidx_q - CNT_W'(1)];
                    end
                end
                SH_STORE: hcnt_q <= '0;
                default:  hcnt_q <= '0;
            endcase
        end
    end

    // outputs
    always_comb begin
        sclk   = rising ? (state_q == SH_DRIVE) : (state_q != SH_DRIVE);
        sdata  = sdata_q;
        sstore = (state_q == SH_STORE);
        busy   = (state_q != SH_IDLE);
    end

endmodule

// File: rtl/sro_cascade_drv.sv
module sro_cascade_drv #(
    parameter int GROUPS   = 3,
    parameter int GW       = 8,
    parameter int DSL_BITS = 2,
    parameter int PHYS     = 4,
    parameter int PHY_BITS = 3,
    parameter int DIV_W    = 8,
    parameter logic [GROUPS*GW-1:0] DEFAULT_IMG = 24'h00FF00
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [2:0]                  wr_addr,
    input  logic [GROUPS*GW-1:0]        wr_data,
    input  logic [DSL_BITS-1:0]         dsl_stat,
    input  logic [PHYS*PHY_BITS-1:0]    phy_stat,
    output logic                        sclk,
    output logic                        sdata,
    output logic                        sstore
);

    localparam int IMG_W    = GROUPS * GW;
    localparam int PHY_EN_W = PHYS * PHY_BITS;

    logic [IMG_W-1:0]    sw_img;
    logic [IMG_W-1:0]    img_merged;
    logic [GROUPS-1:0]   grp_mask;
    logic [DSL_BITS-1:0] dsl_en;
    logic [PHY_EN_W-1:0] phy_en;
    logic                cfg_rising;
    logic [DIV_W-1:0]    half_n;
    logic                busy;

    sro_cfg_regs #(
        .IMG_W(IMG_W), .GROUPS(GROUPS), .DSL_BITS(DSL_BITS),
        .PHY_EN_W(PHY_EN_W), .DIV_W(DIV_W), .DEFAULT_IMG(DEFAULT_IMG)
    ) regs_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .sw_img(sw_img), .grp_mask(grp_mask),
        .dsl_en(dsl_en), .phy_en(phy_en), .rising(cfg_rising), .half_n(half_n)
    );

    sro_src_merge #(
        .IMG_W(IMG_W), .DSL_BITS(DSL_BITS), .PHYS(PHYS), .PHY_BITS(PHY_BITS)
    ) merge_i (
        .sw_img(sw_img), .dsl_en(dsl_en), .dsl_stat(dsl_stat),
        .phy_en(phy_en), .phy_stat(phy_stat), .img_merged(img_merged)
    );

    sro_shift_fsm #(
        .IMG_W(IMG_W), .GW(GW), .GROUPS(GROUPS), .DIV_W(DIV_W),
        .DEFAULT_IMG(DEFAULT_IMG)
    ) fsm_i (
        .clk(clk), .rst_n(rst_n), .img_merged(img_merged), .grp_mask(grp_mask),
        .rising(cfg_rising), .half_n(half_n), .sclk(sclk), .sdata(sdata),
        .sstore(sstore), .busy(busy)
    );

endmodule

// File: rtl/sro_cascade_drv_chk.sv
module sro_cascade_drv_chk #(
    parameter int GROUPS = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sclk,
    input logic              sdata,
    input logic              sstore,
    input logic              busy,
    input logic              cfg_rising,
    input logic [GROUPS-1:0] grp_mask
);

    logic act;
    assign act = cfg_rising ? sclk : !sclk;

    a_r4_store_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        sstore |=> !sstore);

    a_r4_store_after_frame: assert property (@(posedge clk) disable iff (!rst_n)
        sstore |-> $past(busy));

    a_r2_data_stable_at_edge: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(act) |-> $stable(sdata));

    a_r5_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !act);

    a_r3_no_frame_without_group: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ($past(grp_mask) != '0));

endmodule

bind sro_cascade_drv sro_cascade_drv_chk #(.GROUPS(GROUPS)) chk_i (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .sdata(sdata), .sstore(sstore),
    .busy(busy), .cfg_rising(cfg_rising), .grp_mask(grp_mask)
);

// File: tb/sro_cascade_drv_tb_top.sv
module sro_cascade_drv_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [23:0] wr_data = '0;
    logic [1:0]  dsl_stat = '0;
    logic [11:0] phy_stat = '0;
    logic        sclk, sdata, sstore;

    int n_chk = 0;
    int n_err = 0;

    sro_cascade_drv dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .dsl_stat(dsl_stat), .phy_stat(phy_stat),
        .sclk(sclk), .sdata(sdata), .sstore(sstore)
    );

    always #4 clk = ~clk;

    // monitor state
    logic        tb_rising = 1'b0;
    logic        act_prev = 1'b0;
    logic        st_prev = 1'b0;
    logic        store_wide = 1'b0;
    logic [23:0] cap_v = '0;
    int          cap_n = 0;
    int          frames = 0;
    int          cyc = 0;
    int          last_edge = 0;
    int          gap = 0;
    logic [23:0] fr_v [4];
    int          fr_n [4];
    int          fr_gap [4];

    always @(negedge clk) begin
        logic a;
        cyc = cyc + 1;
        if (rst_n) begin
            a = tb_rising ? sclk : !sclk;
            if (a && !act_prev) begin
                if (cap_n > 0) gap = cyc - last_edge;
                last_edge = cyc;
                cap_v = {cap_v[22:0], sdata};
                cap_n = cap_n + 1;
            end
            if (sstore && st_prev) store_wide = 1'b1;
            if (sstore) begin
                fr_v[frames & 3]   = cap_v;
                fr_n[frames & 3]   = cap_n;
                fr_gap[frames & 3] = gap;
                frames = frames + 1;
                cap_v = '0;
                cap_n = 0;
            end
            act_prev = a;
            st_prev  = sstore;
        end
    end

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [23:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic clr();
        @(posedge clk);
        frames = 0; cap_n = 0; cap_v = '0; store_wide = 1'b0;
    endtask

    task automatic wait_frames(input int k);
        int t = 0;
        while (frames < k && t < 6000) begin
            @(posedge clk);
            t++;
        end
        repeat (3) @(posedge clk);
    endtask

    function automatic logic [23:0] pk(input logic [23:0] img, input logic [2:0] m);
        logic [23:0] f = '0;
        int n = 0;
        for (int g = 0; g < 3; g++) begin
            if (m[g]) begin
                f = f | ({16'h0, img[g*8 +: 8]} << n);
                n = n + 8;
            end
        end
        return f;
    endfunction

    task automatic t_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1", "idle sclk high", 32'(sclk), 32'd1);
        chk("R1", "store low", 32'(sstore), 32'd0);
        repeat (100) @(posedge clk);
        chk("R1", "no frame after reset", frames, 0);
    endtask

    task automatic t_full();
        clr();
        wr(3'd0, 24'hA5C33C);
        wait_frames(1);
        chk("R2", "frame length", fr_n[0], 24);
        chk("R2", "frame bits", 32'(fr_v[0]), 32'hA5C33C);
        chk("R4", "store single cycle", 32'(store_wide), 32'd0);
    endtask

    task automatic t_masks();
        wr(3'd1, 24'd5);
        clr();
        wr(3'd0, 24'h123456);
        wait_frames(1);
        chk("R3", "mask 101 length", fr_n[0], 16);
        chk("R3", "mask 101 bits", 32'(fr_v[0]), 32'(pk(24'h123456, 3'b101)));
        wr(3'd1, 24'd2);
        clr();
        wr(3'd0, 24'h9ABCDE);
        wait_frames(1);
        chk("R3", "mask 010 length", fr_n[0], 8);
        chk("R3", "mask 010 bits", 32'(fr_v[0]), 32'hBC);
        wr(3'd1, 24'd0);
        clr();
        wr(3'd0, 24'h0F0F0F);
        repeat (300) @(posedge clk);
        chk("R3", "mask 0 sends nothing", frames, 0);
        wr(3'd1, 24'd7);
        wait_frames(1);
        chk("R3", "pending sent after re-enable", 32'(fr_v[0]), 32'h0F0F0F);
    endtask

    task automatic t_nochange();
        clr();
        wr(3'd0, 24'h0F0F0F);
        repeat (300) @(posedge clk);
        chk("R9", "same value no frame", frames, 0);
    endtask

    task automatic t_dsl();
        dsl_stat = 2'b11;
        clr();
        wr(3'd0, 24'h0F0F0C);
        wait_frames(1);
        chk("R7", "disabled DSL ignored", 32'(fr_v[0]), 32'h0F0F0C);
        clr();
        wr(3'd2, 24'd2);
        wait_frames(1);
        chk("R7", "DSL bit1 override", 32'(fr_v[0]), 32'h0F0F0E);
        clr();
        @(negedge clk) dsl_stat = 2'b01;
        wait_frames(1);
        chk("R9", "status-only frame count", frames, 1);
        chk("R9", "status-only frame bits", 32'(fr_v[0]), 32'h0F0F0C);
    endtask

    task automatic t_phy();
        phy_stat = 12'hFFF;
        clr();
        wr(3'd0, 24'h000000);
        wait_frames(1);
        chk("R8", "disabled PHYs ignored", 32'(fr_v[0]), 32'h000000);
        clr();
        wr(3'd3, 24'h1C0);
        wait_frames(1);
        chk("R8", "PHY2 bits 10:8", 32'(fr_v[0]), 32'h000700);
        clr();
        wr(3'd3, 24'hFC0);
        wait_frames(1);
        chk("R8", "PHY2+PHY3 bits 13:8", 32'(fr_v[0]), 32'h003F00);
        wr(3'd2, 24'd0);
        wr(3'd3, 24'd0);
        @(negedge clk) begin dsl_stat = 2'b00; phy_stat = 12'h000; end
        repeat (400) @(posedge clk);
    endtask

    task automatic t_rising();
        wr(3'd4, 24'h21);
        tb_rising = 1'b1;
        repeat (5) @(posedge clk);
        @(negedge clk);
        chk("R5", "rising idle low", 32'(sclk), 32'd0);
        clr();
        wr(3'd0, 24'h3C6681);
        wait_frames(1);
        chk("R5", "rising frame bits", 32'(fr_v[0]), 32'h3C6681);
        chk("R5", "rising frame length", fr_n[0], 24);
    endtask

    task automatic t_divider();
        wr(3'd4, 24'h51);
        clr();
        wr(3'd0, 24'h111111);
        wait_frames(1);
        chk("R6", "edge spacing N=5", fr_gap[0], 10);
        chk("R6", "N=5 bits", 32'(fr_v[0]), 32'h111111);
        wr(3'd4, 24'h01);
        clr();
        wr(3'd0, 24'h222222);
        wait_frames(1);
        chk("R6", "edge spacing N=0", fr_gap[0], 2);
        chk("R6", "N=0 bits", 32'(fr_v[0]), 32'h222222);
        wr(3'd4, 24'h20);
        tb_rising = 1'b0;
        repeat (10) @(posedge clk);
    endtask

    task automatic t_midframe();
        int t = 0;
        clr();
        wr(3'd0, 24'hAAAAAA);
        while (cap_n < 5 && t < 2000) begin
            @(posedge clk);
            t++;
        end
        wr(3'd0, 24'h555555);
        wait_frames(2);
        chk("R10", "first frame intact", 32'(fr_v[0]), 32'hAAAAAA);
        chk("R10", "first frame length", fr_n[0], 24);
        chk("R10", "second frame new", 32'(fr_v[1]), 32'h555555);
        repeat (300) @(posedge clk);
        chk("R10", "exactly two frames", frames, 2);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        t_reset();
        t_full();
        t_masks();
        t_nochange();
        t_dsl();
        t_phy();
        t_rising();
        t_divider();
        t_midframe();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
        $finish;
    end

endmodule